// File: doc/BRIEF.md
# Dual-Mode Stack Access Sequencer

This block produces the stack bus cycles of a processor that has a 16-bit stack pointer and a legacy emulation mode. A request gives the direction (push or pull), a byte count from one to three, the bytes to store, and a flag that chooses the pointer model for this request. The paged model honours emulation mode. The flat model always uses the whole 16-bit pointer. The sequencer owns the stack pointer. It runs a short preamble of internal cycles, then one bus access per byte. Each pulled byte comes back with a strobe, and a one-cycle done pulse follows the last access.

While emulation is on, the paged model fixes the upper byte of every stack address to page 1 and moves only the low byte of the pointer, so the pointer wraps inside that page. The flat model, and either model while emulation is off, counts across the full 16-bit range. The complete pointer is always visible on an output for debug, whatever the mode. A register-file write port loads the pointer. A rising edge on the emulation input clamps the pointer's upper byte to page 1.

Top module: `stack_seq`

## Requirements
- R1: After reset the pointer reads 0x01FF, `phase` is 00 (idle), `done` is low and `mem_we` is low.
- R2: When `emu` is 1 and `req_native` is 0, every stack address is {0x01, pointer[7:0]}. Such an access changes only pointer[7:0], which wraps 0x00 to 0xFF on a push and 0xFF to 0x00 on a pull.
- R3: When `req_native` is 1 or `emu` is 0, the stack address is the full 16-bit pointer. The pointer steps by one across page boundaries.
- R4: A push writes at the current pointer and then decrements it. It sends bytes from the highest field down, where field k is `req_data[8k+7:8k]`. A pull first increments the pointer and then reads at the new address. It returns field 0 first on `pull_byte`, with `pull_valid` high in the read cycle.
- R5: `phase` encodes 00 idle, 01 internal, 10 stack write, 11 stack read. A push starts with one internal cycle and a pull starts with two. Exactly one access cycle follows per byte. `done` is high for exactly one cycle right after the last access, with `phase` 00 in that cycle.
- R6: `start` is accepted only when the block is idle and `done` is low. A `start` seen during a sequence or during its done cycle has no effect. `sp_load` is honoured only when idle.
- R7: A request with `req_count` of 0 is ignored. `phase` stays 00 and the pointer does not change.
- R8: A rising edge on `emu` sets pointer[15:8] to 0x01 and keeps pointer[7:0]. A flat-model access made in emulation may leave the pointer outside page 1.
- R9: `sp` always shows all 16 bits of the pointer, whatever the value of `emu`.
- R10: A three-byte push stores field 2, then field 1, then field 0, at descending addresses. A three-byte pull returns field 0, then field 1, then field 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emu | input | 1 | Emulation mode level |
| sp_load | input | 1 | Load the pointer from sp_load_val (idle only) |
| sp_load_val | input | PTR_W | Pointer load value |
| start | input | 1 | Request strobe |
| req_push | input | 1 | 1 = push, 0 = pull |
| req_native | input | 1 | 1 = flat 16-bit model, 0 = honour emulation |
| req_count | input | clog2(MAX_BYTES+1) | Bytes to move |
| req_data | input | MAX_BYTES*BYTE_W | Bytes to push, field k at bits 8k+7:8k |
| mem_addr | output | PTR_W | Stack address |
| mem_wdata | output | BYTE_W | Write byte |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | BYTE_W | Read byte, valid in the read cycle |
| phase | output | 2 | Cycle kind |
| pull_valid | output | 1 | Pulled byte valid |
| pull_byte | output | BYTE_W | Pulled byte |
| done | output | 1 | Sequence finished |
| busy | output | 1 | Not idle |
| sp | output | PTR_W | Full stack pointer |

## Verification
The bench uses the default parameters: a 16-bit pointer, 8-bit bytes, at most three bytes per request, and page 1 as the emulation page. With three bytes the long call and long return orderings can be exercised. Page 1 keeps the in-page wrap and the flat model's escape from page 1 to page 0 within a handful of accesses. A small request count also keeps the byte-field selection exhaustively covered.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int PTR_W = 16,
  parameter int BYTE_W = 8,
  parameter int MAX_BYTES = 3,
  parameter logic [PTR_W-9:0] EMU_PAGE = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          emu,
  input  logic                          sp_load,
  input  logic [PTR_W-1:0]              sp_load_val,
  input  logic                          start,
  input  logic                          req_push,
  input  logic                          req_native,
  input  logic [$clog2(MAX_BYTES+1)-1:0] req_count,
  input  logic [MAX_BYTES*BYTE_W-1:0]   req_data,
  output logic [PTR_W-1:0]              mem_addr,
  output logic [BYTE_W-1:0]             mem_wdata,
  output logic                          mem_we,
  output logic                          mem_re,
  input  logic [BYTE_W-1:0]             mem_rdata,
  output logic [1:0]                    phase,
  output logic                          pull_valid,
  output logic [BYTE_W-1:0]             pull_byte,
  output logic                          done,
  output logic                          busy,
  output logic [PTR_W-1:0]              sp
);
  localparam int CNT_W = $clog2(MAX_BYTES+1);
  localparam logic [PTR_W-1:0] SP_RESET = {EMU_PAGE, 8'hFF};

  typedef enum logic [1:0] {S_IDLE, S_INT, S_ACC, S_DONE} state_t;

  state_t                      state;
  logic                        push_q, nat_q, emu_q, pre_q;
  logic [CNT_W-1:0]            bcnt;
  logic [MAX_BYTES*BYTE_W-1:0] data_q, data_sh;
  logic [PTR_W-1:0]            sp_inc, sp_dec, tgt, sp_nx;
  logic                        paged, accept;

  assign paged  = emu && !nat_q;
  assign accept = start && state == S_IDLE && req_count != '0 && int'(req_count) <= MAX_BYTES;
  assign sp_inc = paged ? {sp[PTR_W-1:8], sp[7:0] + 8'd1} : sp + 1'b1;
  assign sp_dec = paged ? {sp[PTR_W-1:8], sp[7:0] - 8'd1} : sp - 1'b1;
  assign tgt    = push_q ? sp : sp_inc;

  assign busy       = state != S_IDLE;
  assign done       = state == S_DONE;
  assign mem_we     = state == S_ACC && push_q;
  assign mem_re     = state == S_ACC && !push_q;
  assign mem_addr   = state != S_ACC ? '0 : (paged ? {EMU_PAGE, tgt[7:0]} : tgt);
  assign data_sh    = data_q >> (BYTE_W * (int'(bcnt) - 1));
  assign mem_wdata  = mem_we ? data_sh[BYTE_W-1:0] : '0;
  assign pull_valid = mem_re;
  assign pull_byte  = mem_re ? mem_rdata : '0;
  assign phase      = state == S_INT ? 2'b01 : (state == S_ACC ? {1'b1, !push_q} : 2'b00);

  always_comb begin
    sp_nx = sp;
    if (state == S_IDLE && sp_load) sp_nx = sp_load_val;
    else if (state == S_ACC) sp_nx = push_q ? sp_dec : sp_inc;
    if (emu && !emu_q) sp_nx[PTR_W-1:8] = EMU_PAGE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sp     <= SP_RESET;
      emu_q  <= 1'b0;
      push_q <= 1'b0;
      nat_q  <= 1'b0;
      pre_q  <= 1'b0;
      bcnt   <= '0;
      data_q <= '0;
    end else begin
      sp    <= sp_nx;
      emu_q <= emu;
      case (state)
        S_IDLE: if (accept) begin
          state  <= S_INT;
          push_q <= req_push;
          nat_q  <= req_native;
          pre_q  <= !req_push;
          bcnt   <= req_count;
          data_q <= req_data;
        end
        S_INT: begin
          if (pre_q) pre_q <= 1'b0;
          else state <= S_ACC;
        end
        S_ACC: begin
          bcnt <= bcnt - 1'b1;
          if (bcnt == CNT_W'(1)) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int PTR_W = 16,
  parameter logic [PTR_W-9:0] EMU_PAGE = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             emu,
  input logic             nat,
  input logic [1:0]       phase,
  input logic             done,
  input logic             mem_we,
  input logic [PTR_W-1:0] mem_addr,
  input logic [PTR_W-1:0] sp
);
  AST_PAGED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[1] && emu && !nat) |-> mem_addr[PTR_W-1:8] == EMU_PAGE); // R2
  AST_FLAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b10 && (nat || !emu)) |=> (sp == $past(sp) - 1'b1) || $rose(emu)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> phase == 2'b00 && !mem_we); // R5
  AST_EMU_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(emu) |=> sp[PTR_W-1:8] == EMU_PAGE); // R8
endmodule

bind stack_seq stack_seq_chk #(.PTR_W(PTR_W), .EMU_PAGE(EMU_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .emu(emu), .nat(nat_q), .phase(phase),
  .done(done), .mem_we(mem_we), .mem_addr(mem_addr), .sp(sp)
);

// File: tb/sim_stack_seq.sv
`timescale 1ns/1ps
module sim_stack_seq;
  logic clk = 0, rst_n = 0;
  logic emu = 1, sp_load = 0, start = 0, req_push = 0, req_native = 0;
  logic [15:0] sp_load_val = 0;
  logic [1:0]  req_count = 0;
  logic [23:0] req_data = 0;
  logic [15:0] mem_addr, sp;
  logic [7:0]  mem_wdata, mem_rdata, pull_byte;
  logic mem_we, mem_re, pull_valid, done, busy;
  logic [1:0] phase;

  logic [7:0] mem [0:65535];
  logic [7:0] mmem [int];
  logic [15:0] msp;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  stack_seq u0 (.clk(clk), .rst_n(rst_n), .emu(emu), .sp_load(sp_load),
    .sp_load_val(sp_load_val), .start(start), .req_push(req_push),
    .req_native(req_native), .req_count(req_count), .req_data(req_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .phase(phase), .pull_valid(pull_valid),
    .pull_byte(pull_byte), .done(done), .busy(busy), .sp(sp));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] eaddr(input logic [15:0] s, input bit paged);
    return paged ? {8'h01, s[7:0]} : s;
  endfunction

  task automatic run(input bit push, input int n, input bit nat, input logic [23:0] d, input bit poke);
    bit pg = emu && !nat;
    logic [15:0] ea;
    logic [7:0] b;
    @(negedge clk);
    start = 1; req_push = push; req_native = nat; req_count = 2'(n); req_data = d;
    @(negedge clk);
    start = poke; req_push = !push; req_count = 2'd1; req_data = 24'h5A5A5A;
    sp_load = poke; sp_load_val = 16'hFFFF;
    chk(phase == 2'b01 && sp == msp, "R5 internal", {phase, sp}, {2'b01, msp});
    if (!push) begin
      @(negedge clk);
      start = 0; sp_load = 0;
      chk(phase == 2'b01 && sp == msp, "R5 internal2", {phase, sp}, {2'b01, msp});
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 0; sp_load = 0;
      chk(sp == msp, "R9 sp", sp, msp);
      if (push) begin
        ea = eaddr(msp, pg);
        b = d[8*(n-1-i) +: 8];
        mmem[ea] = b;
        chk(mem_addr == ea, pg ? "R2 push addr" : "R3 push addr", mem_addr, ea);
        chk(phase == 2'b10 && mem_we && mem_wdata == b, n == 3 ? "R10 push order" : "R4 push byte",
            {phase, mem_we, mem_wdata}, {2'b10, 1'b1, b});
        msp = pg ? {msp[15:8], msp[7:0] - 8'd1} : msp - 16'd1;
      end else begin
        msp = pg ? {msp[15:8], msp[7:0] + 8'd1} : msp + 16'd1;
        ea = eaddr(msp, pg);
        b = mmem.exists(ea) ? mmem[ea] : 8'h00;
        chk(mem_addr == ea, pg ? "R2 pull addr" : "R3 pull addr", mem_addr, ea);
        chk(phase == 2'b11 && pull_valid && pull_byte == b, n == 3 ? "R10 pull order" : "R4 pull byte",
            {phase, pull_valid, pull_byte}, {2'b11, 1'b1, b});
      end
    end
    @(negedge clk);
    chk(done && phase == 2'b00 && sp == msp, "R5 done", {done, phase, sp}, {1'b1, 2'b00, msp});
    start = poke;
    @(negedge clk);
    start = 0;
    chk(!done && phase == 2'b00, "R5 done single", {done, phase}, {1'b0, 2'b00});
    @(negedge clk);
    chk(phase == 2'b00 && sp == msp, "R6 start ignored", {phase, sp}, {2'b00, msp});
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk); sp_load = 1; sp_load_val = v;
    @(negedge clk); sp_load = 0; msp = v;
    chk(sp == v, "R9 load", sp, v);
  endtask

  task automatic set_emu(input bit v);
    bit rise = v && !emu;
    @(negedge clk); emu = v;
    @(negedge clk);
    if (rise) msp[15:8] = 8'h01;
    chk(sp == msp, "R8 emu clamp", sp, msp);
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    msp = 16'h01FF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sp == 16'h01FF && phase == 2'b00 && !done && !mem_we, "R1 reset",
        {sp, phase, done, mem_we}, {16'h01FF, 2'b00, 1'b0, 1'b0});
    run(1, 1, 0, 24'h0000A5, 0);
    run(0, 1, 0, 24'h0, 0);
    load(16'h0100);
    run(1, 2, 0, 24'h00BEEF, 0);
    chk(sp == 16'h01FE, "R2 wrap in page", sp, 16'h01FE);
    run(0, 2, 0, 24'h0, 0);
    run(1, 2, 1, 24'h001234, 1);
    chk(sp == 16'h00FE, "R8 leaves page", sp, 16'h00FE);
    run(0, 2, 1, 24'h0, 1);
    load(16'h2000);
    run(1, 3, 1, 24'h7E8C91, 0);
    run(0, 3, 1, 24'h0, 0);
    set_emu(0);
    load(16'h1200);
    run(1, 1, 0, 24'h000042, 0);
    chk(sp == 16'h11FF, "R3 page cross", sp, 16'h11FF);
    run(0, 1, 0, 24'h0, 0);
    load(16'h3456);
    set_emu(1);
    chk(sp == 16'h0156, "R8 clamp value", sp, 16'h0156);
    @(negedge clk); start = 1; req_push = 1; req_count = 2'd0;
    @(negedge clk); start = 0;
    chk(phase == 2'b00 && !busy, "R7 zero count", {phase, busy}, 3'b000);
    @(negedge clk);
    chk(phase == 2'b00 && sp == msp, "R7 zero count sp", sp, msp);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule